// File: doc/BRIEF.md
# Four-Channel DMA Address Sequencer

This block holds the addressing state for a small DMA engine with up to four channels. For each channel it keeps a current address, an initial address, a transfer counter and a counter reload value. Two shared 16-bit control words set the per-channel options. The first selects the target bus and the transfer direction. The second holds the interrupt enable, the interrupt pending flag, the reload mode and the address-update enable. Software reaches all of this through a simple write strobe with a combinational read port.

The data mover asserts `xfer_valid` with a channel number once for each completed transfer. It can accept at most one strobe per clock. In that cycle the block presents the channel's current address and raises a one-hot request towards the selected bus. On the clock edge it updates the channel's address and counter. An address can stay fixed, advance by one, or jump back to the initial address when the counter has run out. This gives circular buffers without software help. Reaching a count of zero latches a pending flag, which becomes an interrupt request when it is enabled and the external `pend_en` input is high.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset every register reads 0x0000, no interrupt is raised and all bus-select and direction outputs are 0.
- R2: The bus/direction word at offset 0x40 gives channel c the bits [4c+2:4c]. Bits [4c+1:4c] select the bus (00 X, 01 Y, 10 I, 11 reserved) and bit 4c+2 sets the direction (1 = read, 0 = write). Bit 4c+3 ignores writes and reads 0. The fields drive `ch_bus_sel[2c+1:2c]` and `ch_dir[c]`.
- R3: The control word at offset 0x42 gives channel c the nibble [4c+3:4c]. Bit 4c is the interrupt enable, 4c+1 is pending, 4c+2 is reload mode and 4c+3 is address-update enable. Enable, reload mode and update enable are plain read/write bits.
- R4: Channel c's registers sit at byte offsets 8c (current address), 8c+2 (initial address), 8c+4 (counter) and 8c+6 (reload value). A write to any other offset changes nothing, and such offsets read 0.
- R5: While `xfer_valid` is high, `xfer_addr` shows the strobed channel's current address. `xfer_bus_req` is one-hot on the selected bus (bit 0 X, bit 1 Y, bit 2 I). It is all zero for the reserved code and whenever no strobe is present.
- R6: With address-update enable at 0, a transfer leaves the channel's current address unchanged.
- R7: With update enable at 1 and reload mode at 0, a transfer adds one to the current address, wrapping from 0xFFFF to 0x0000.
- R8: With update enable at 1 and reload mode at 1, a transfer loads the initial address when the counter is 0 and otherwise adds one.
- R9: A transfer decrements a non-zero counter and loads a zero counter from the reload value. If the resulting counter is 0, the channel's pending bit is set.
- R10: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. A set by a transfer in the same cycle overrides the clear.
- R11: `irq[c]` is high exactly when channel c's pending and enable bits are both 1 and `pend_en` is high.
- R12: A register write to a channel's current address or counter in the same cycle as a transfer on that channel takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for reads and writes |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| xfer_valid | input | 1 | One transfer completed this cycle |
| xfer_ch | input | 2 | Channel of the completed transfer |
| pend_en | input | 1 | Global gate for pending interrupts |
| xfer_addr | output | 16 | Current address of the strobed channel |
| xfer_bus_req | output | 3 | One-hot bus request for the strobed channel |
| ch_bus_sel | output | 8 | Bus code of each channel, 2 bits each |
| ch_dir | output | 4 | Direction of each channel, 1 = read |
| irq | output | 4 | Interrupt request per channel |

## Verification
Two pairs of events can land in the same cycle. In the first, a transfer's counter reaching zero coincides with a software write-one-to-clear of that channel's pending bit. In the second, a transfer's address or counter update coincides with a software write to that same register. Directed steps arrange both collisions by loading the counter with 1 and then issuing the clear or the overwrite together with the strobe. The random phase keeps small counter values so that collisions recur. The bench judges each outcome by reading back the pending bit, the address and the counter and comparing them with a reference model that applies the transfer first and the software write on top, with the hardware set winning over the clear.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   // shared control words
   localparam logic [7:0] GC_OFS    = 8'h40;
   localparam logic [7:0] AI_OFS    = 8'h42;
   // per-channel window
   localparam int         CH_STRIDE = 8;
   localparam logic [1:0] SUB_CUR   = 2'd0;
   localparam logic [1:0] SUB_INIT  = 2'd1;
   localparam logic [1:0] SUB_CNT   = 2'd2;
   localparam logic [1:0] SUB_RLD   = 2'd3;
   // nibble positions
   localparam int         NIB       = 4;
   localparam int         GC_DIR    = 2;
   localparam int         AI_IE     = 0;
   localparam int         AI_PEND   = 1;
   localparam int         AI_LDM    = 2;
   localparam int         AI_AUE    = 3;
   localparam int         NBUS      = 3;

   typedef enum logic [1:0] {
      BUS_X   = 2'b00,
      BUS_Y   = 2'b01,
      BUS_I   = 2'b10,
      BUS_RSV = 2'b11
   } bus_code_e;
endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
   parameter int AW = 16,
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_cur,
   input  logic          wr_init,
   input  logic          wr_cnt,
   input  logic          wr_rld,
   input  logic [15:0]   wdata,
   input  logic          xfer,
   input  logic          aue,
   input  logic          ldm,
   output logic [AW-1:0] cur_q,
   output logic [AW-1:0] init_q,
   output logic [CW-1:0] cnt_q,
   output logic [CW-1:0] rld_q,
   output logic          cnt_hit
);
   timeunit 1ns;
   timeprecision 100ps;

   logic          cnt_zero;
   logic [CW-1:0] cnt_nx;
   logic [AW-1:0] cur_nx;

   always_comb begin
      cnt_zero = (cnt_q == '0);
      cnt_nx   = cnt_zero ? rld_q : cnt_q - 1'b1;
      cur_nx   = cur_q;
      if (aue) begin
         cur_nx = (ldm && cnt_zero) ? init_q : cur_q + 1'b1;
      end
   end

   assign cnt_hit = xfer && (cnt_nx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         init_q <= '0;
         cnt_q  <= '0;
         rld_q  <= '0;
      end else begin
         if (wr_cur)      cur_q <= wdata[AW-1:0];
         else if (xfer)   cur_q <= cur_nx;
         if (wr_cnt)      cnt_q <= wdata[CW-1:0];
         else if (xfer)   cnt_q <= cnt_nx;
         if (wr_init)     init_q <= wdata[AW-1:0];
         if (wr_rld)      rld_q  <= wdata[CW-1:0];
      end
   end
endmodule

// File: rtl/dma_ctrl_regs.sv
module dma_ctrl_regs
   import dma_seq_pkg::*;
#(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_gc,
   input  logic           wr_ai,
   input  logic [15:0]    wdata,
   input  logic [NCH-1:0] set_pend,
   output logic [15:0]    gc_q,
   output logic [15:0]    ai_q
);
   timeunit 1ns;
   timeprecision 100ps;

   for (genvar c = 0; c < 16 / NIB; c++) begin : g_nib
      if (c < NCH) begin : g_live
         logic [2:0] gc_r;
         logic       ie_r, pend_r, ldm_r, aue_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gc_r   <= '0;
               ie_r   <= 1'b0;
               pend_r <= 1'b0;
               ldm_r  <= 1'b0;
               aue_r  <= 1'b0;
            end else begin
               if (wr_gc) gc_r <= wdata[NIB*c +: 3];
               if (wr_ai) begin
                  ie_r  <= wdata[NIB*c + AI_IE];
                  ldm_r <= wdata[NIB*c + AI_LDM];
                  aue_r <= wdata[NIB*c + AI_AUE];
               end
               // hardware set overrides write-one-to-clear
               pend_r <= set_pend[c] | (pend_r & ~(wr_ai & wdata[NIB*c + AI_PEND]));
            end
         end

         assign gc_q[NIB*c +: NIB] = {1'b0, gc_r};
         assign ai_q[NIB*c +: NIB] = {aue_r, ldm_r, pend_r, ie_r};
      end else begin : g_dead
         assign gc_q[NIB*c +: NIB] = '0;
         assign ai_q[NIB*c +: NIB] = '0;
      end
   end
endmodule

// File: rtl/dma_bus_dec.sv
module dma_bus_dec
   import dma_seq_pkg::*;
(
   input  logic            valid,
   input  logic [1:0]      code,
   output logic [NBUS-1:0] req
);
   timeunit 1ns;
   timeprecision 100ps;

   for (genvar b = 0; b < NBUS; b++) begin : g_bus
      assign req[b] = valid && (code == 2'(b));
   end
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
   import dma_seq_pkg::*;
#(
   parameter  int NCH = 4,
   parameter  int AW  = 16,
   parameter  int CW  = 16,
   parameter  int RAW = 8,
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [RAW-1:0]   reg_addr,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic             xfer_valid,
   input  logic [CHW-1:0]   xfer_ch,
   input  logic             pend_en,
   output logic [AW-1:0]    xfer_addr,
   output logic [NBUS-1:0]  xfer_bus_req,
   output logic [2*NCH-1:0] ch_bus_sel,
   output logic [NCH-1:0]   ch_dir,
   output logic [NCH-1:0]   irq
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int WIN = NCH * CH_STRIDE;

   if (NCH < 1 || NCH > 4) begin : g_bad_nch
      $error("dma_addr_seq: NCH must be 1..4");
   end
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("dma_addr_seq: AW must be 1..16");
   end
   if (CW < 1 || CW > 16) begin : g_bad_cw
      $error("dma_addr_seq: CW must be 1..16");
   end
   if (RAW < 7) begin : g_bad_raw
      $error("dma_addr_seq: RAW must be at least 7");
   end

   logic [AW-1:0]     cur_q  [NCH];
   logic [AW-1:0]     init_q [NCH];
   logic [CW-1:0]     cnt_q  [NCH];
   logic [CW-1:0]     rld_q  [NCH];
   logic [1:0]        bus_of [NCH];
   logic [NCH-1:0]    xfer_sel, cnt_hit;
   logic [15:0]       gc_q, ai_q;
   logic [NCH*AW-1:0] cur_flat;
   logic              ch_space, wr_gc, wr_ai;
   logic [1:0]        sub;
   logic [CHW-1:0]    ch_idx;

   assign ch_space = (reg_addr < RAW'(WIN)) && !reg_addr[0];
   assign sub      = reg_addr[2:1];
   assign ch_idx   = reg_addr[3 +: CHW];
   assign wr_gc    = reg_wr && (reg_addr == RAW'(GC_OFS));
   assign wr_ai    = reg_wr && (reg_addr == RAW'(AI_OFS));

   dma_ctrl_regs #(.NCH(NCH)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_gc    (wr_gc),
      .wr_ai    (wr_ai),
      .wdata    (reg_wdata),
      .set_pend (cnt_hit),
      .gc_q     (gc_q),
      .ai_q     (ai_q)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit         = reg_wr && ch_space && (ch_idx == CHW'(c));
      assign xfer_sel[c] = xfer_valid && (xfer_ch == CHW'(c));

      dma_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_cur  (hit && (sub == SUB_CUR)),
         .wr_init (hit && (sub == SUB_INIT)),
         .wr_cnt  (hit && (sub == SUB_CNT)),
         .wr_rld  (hit && (sub == SUB_RLD)),
         .wdata   (reg_wdata),
         .xfer    (xfer_sel[c]),
         .aue     (ai_q[NIB*c + AI_AUE]),
         .ldm     (ai_q[NIB*c + AI_LDM]),
         .cur_q   (cur_q[c]),
         .init_q  (init_q[c]),
         .cnt_q   (cnt_q[c]),
         .rld_q   (rld_q[c]),
         .cnt_hit (cnt_hit[c])
      );

      assign cur_flat[c*AW +: AW] = cur_q[c];
      assign bus_of[c]            = gc_q[NIB*c +: 2];
      assign ch_bus_sel[2*c +: 2] = bus_of[c];
      assign ch_dir[c]            = gc_q[NIB*c + GC_DIR];
      assign irq[c]               = pend_en && ai_q[NIB*c + AI_IE] && ai_q[NIB*c + AI_PEND];
   end

   assign xfer_addr = cur_q[xfer_ch];

   dma_bus_dec u_bus (
      .valid (xfer_valid),
      .code  (bus_of[xfer_ch]),
      .req   (xfer_bus_req)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == RAW'(GC_OFS)) begin
         reg_rdata = gc_q;
      end else if (reg_addr == RAW'(AI_OFS)) begin
         reg_rdata = ai_q;
      end else if (ch_space) begin
         case (sub)
            SUB_CUR:  reg_rdata = 16'(cur_q[ch_idx]);
            SUB_INIT: reg_rdata = 16'(init_q[ch_idx]);
            SUB_CNT:  reg_rdata = 16'(cnt_q[ch_idx]);
            default:  reg_rdata = 16'(rld_q[ch_idx]);
         endcase
      end
   end
endmodule

// File: rtl/dma_addr_seq_chk.sv
module dma_addr_seq_chk #(
   parameter int NCH = 4,
   parameter int AW  = 16,
   parameter int RAW = 8
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      reg_wr,
   input logic [RAW-1:0]            reg_addr,
   input logic                      xfer_valid,
   input logic [((NCH > 1) ? $clog2(NCH) : 1)-1:0] xfer_ch,
   input logic                      pend_en,
   input logic [2:0]                xfer_bus_req,
   input logic [2*NCH-1:0]          ch_bus_sel,
   input logic [NCH-1:0]            irq,
   input logic [15:0]               ai_q,
   input logic [NCH*AW-1:0]         cur_flat
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   logic [1:0]     sel_bus;
   logic [3:0]     sel_nib;
   logic [AW-1:0]  sel_cur, cur_now;
   logic           wr_cur_hit;
   logic [CHW-1:0] ch_q;
   logic [NCH-1:0] ie_vec;

   always_comb begin
      sel_bus    = ch_bus_sel[2*xfer_ch +: 2];
      sel_nib    = ai_q[4*xfer_ch +: 4];
      sel_cur    = cur_flat[AW*xfer_ch +: AW];
      cur_now    = cur_flat[AW*ch_q +: AW];
      wr_cur_hit = reg_wr && (reg_addr == RAW'(8*xfer_ch));
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ie
      assign ie_vec[c] = ai_q[4*c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ch_q <= '0;
      else        ch_q <= xfer_ch;
   end

   // R5
   bus_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xfer_bus_req));
   // R5
   bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_valid |-> (xfer_bus_req == 3'b000));
   // R5
   bus_rsv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && sel_bus == 2'b11) |-> (xfer_bus_req == 3'b000));
   // R5
   bus_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && sel_bus != 2'b11) |-> xfer_bus_req[sel_bus]);
   // R6
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && !sel_nib[3] && !wr_cur_hit) |=> (cur_now == $past(sel_cur)));
   // R7
   addr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_valid && sel_nib[3] && !sel_nib[2] && !wr_cur_hit) |=> (cur_now == $past(sel_cur) + 1'b1));
   // R11
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq != '0) |-> pend_en);
   // R11
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq & ~ie_vec) == '0));
endmodule

bind dma_addr_seq dma_addr_seq_chk #(.NCH(NCH), .AW(AW), .RAW(RAW)) u_chk (.*);

// File: tb/tb_dma_addr_seq.sv
module tb_dma_addr_seq;
   timeunit 1ns;
   timeprecision 100ps;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        xfer_valid = 1'b0;
   logic [1:0]  xfer_ch = '0;
   logic        pend_en = 1'b0;
   logic [15:0] xfer_addr;
   logic [2:0]  xfer_bus_req;
   logic [7:0]  ch_bus_sel;
   logic [3:0]  ch_dir;
   logic [3:0]  irq;

   int n_chk = 0;
   int n_err = 0;

   logic [15:0] m_gc, m_ai;
   logic [15:0] m_cur [4];
   logic [15:0] m_init[4];
   logic [15:0] m_cnt [4];
   logic [15:0] m_rld [4];

   always #4 clk = ~clk;

   dma_addr_seq dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_valid(xfer_valid),
      .xfer_ch(xfer_ch), .pend_en(pend_en), .xfer_addr(xfer_addr),
      .xfer_bus_req(xfer_bus_req), .ch_bus_sel(ch_bus_sel), .ch_dir(ch_dir),
      .irq(irq)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rd(input logic [7:0] a);
      if (a == 8'h40) return m_gc;
      if (a == 8'h42) return m_ai;
      if (a < 8'h20 && !a[0]) begin
         case (a[2:1])
            2'd0:    return m_cur[a[4:3]];
            2'd1:    return m_init[a[4:3]];
            2'd2:    return m_cnt[a[4:3]];
            default: return m_rld[a[4:3]];
         endcase
      end
      return 16'h0000;
   endfunction

   function automatic logic [2:0] exp_req(input logic [1:0] ch);
      logic [1:0] b;
      b = m_gc[4*ch +: 2];
      return (b == 2'b11) ? 3'b000 : 3'(1 << b);
   endfunction

   function automatic logic [3:0] exp_irq(input bit pe);
      logic [3:0] r;
      for (int c = 0; c < 4; c++) r[c] = pe & m_ai[4*c] & m_ai[4*c+1];
      return r;
   endfunction

   function automatic string sub_tag(input int s);
      case (s)
         0:       return "R8";
         2:       return "R9";
         default: return "R4";
      endcase
   endfunction

   task automatic model_step(input bit wr, input logic [7:0] a, input logic [15:0] d,
                             input bit xv, input logic [1:0] ch);
      logic [15:0] n_cur [4];
      logic [15:0] n_cnt [4];
      logic [15:0] n_ai;
      bit          setp;
      bit          zero;
      setp  = 1'b0;
      n_cur = m_cur;
      n_cnt = m_cnt;
      n_ai  = m_ai;
      if (xv) begin
         zero      = (m_cnt[ch] == 16'h0);
         n_cnt[ch] = zero ? m_rld[ch] : m_cnt[ch] - 16'd1;
         setp      = (n_cnt[ch] == 16'h0);
         if (m_ai[4*ch+3]) n_cur[ch] = (m_ai[4*ch+2] && zero) ? m_init[ch] : m_cur[ch] + 16'd1;
      end
      if (wr) begin
         if (a == 8'h40) m_gc = d & 16'h7777;
         else if (a == 8'h42) n_ai = (d & 16'hDDDD) | (m_ai & ~d & 16'h2222);
         else if (a < 8'h20 && !a[0]) begin
            case (a[2:1])
               2'd0:    n_cur[a[4:3]]  = d;
               2'd1:    m_init[a[4:3]] = d;
               2'd2:    n_cnt[a[4:3]]  = d;
               default: m_rld[a[4:3]]  = d;
            endcase
         end
      end
      if (setp) n_ai[4*ch+1] = 1'b1;
      m_cur = n_cur;
      m_cnt = n_cnt;
      m_ai  = n_ai;
   endtask

   task automatic verify(input string tag);
      for (int c = 0; c < 4; c++) begin
         for (int s = 0; s < 4; s++) begin
            reg_addr = 8'(c*8 + s*2);
            #0.1;
            chk((tag == "") ? sub_tag(s) : tag, "channel reg", reg_rdata, exp_rd(reg_addr));
         end
      end
      reg_addr = 8'h40; #0.1;
      chk((tag == "") ? "R2" : tag, "bus/dir word", reg_rdata, m_gc);
      reg_addr = 8'h42; #0.1;
      chk((tag == "") ? "R10" : tag, "ctrl word", reg_rdata, m_ai);
      reg_addr = 8'h41; #0.1;
      chk((tag == "") ? "R4" : tag, "unmapped read", reg_rdata, 16'h0000);
      for (int c = 0; c < 4; c++) begin
         chk("R2", "ch_bus_sel", ch_bus_sel[2*c +: 2], m_gc[4*c +: 2]);
         chk("R2", "ch_dir", ch_dir[c], m_gc[4*c+2]);
      end
      chk("R11", "irq", irq, exp_irq(pend_en));
   endtask

   task automatic step(input string tag, input bit wr, input logic [7:0] a, input logic [15:0] d,
                       input bit xv, input logic [1:0] ch, input bit pe);
      reg_wr = wr; reg_addr = a; reg_wdata = d;
      xfer_valid = xv; xfer_ch = ch; pend_en = pe;
      #0.3;
      if (xv) begin
         chk((tag == "") ? "R5" : tag, "xfer_addr", xfer_addr, m_cur[ch]);
         chk("R5", "xfer_bus_req", xfer_bus_req, exp_req(ch));
      end else begin
         chk("R5", "idle bus_req", xfer_bus_req, 3'b000);
      end
      @(posedge clk);
      model_step(wr, a, d, xv, ch);
      @(negedge clk);
      reg_wr = 1'b0; xfer_valid = 1'b0;
      verify(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      logic [7:0]  a;
      logic [15:0] d;
      int          r;
      m_gc = '0; m_ai = '0;
      for (int c = 0; c < 4; c++) begin
         m_cur[c] = '0; m_init[c] = '0; m_cnt[c] = '0; m_rld[c] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      verify("R1");

      // R2: reserved nibble bit dropped
      step("R2", 1, 8'h40, 16'hFFFF, 0, 0, 0);
      // R5: ch0 X write, ch1 Y read, ch2 I, ch3 reserved
      step("R2", 1, 8'h40, 16'h3250, 0, 0, 0);
      step("R4", 1, 8'h00, 16'h1234, 0, 0, 0);
      step("R4", 1, 8'h08, 16'h2000, 0, 0, 0);
      for (int c = 0; c < 4; c++) step("R5", 0, 8'h00, 16'h0, 1, 2'(c), 0);
      // R6: update disabled, address held
      step("R6", 0, 8'h00, 16'h0, 1, 0, 0);
      // R3 plain bits, R7 increment with wrap
      step("R3", 1, 8'h42, 16'h0008, 0, 0, 0);
      step("R7", 1, 8'h00, 16'hFFFF, 0, 0, 0);
      step("R7", 0, 8'h00, 16'h0, 1, 0, 0);
      step("R7", 0, 8'h00, 16'h0, 1, 0, 0);
      // R8 reload from initial address
      step("R3", 1, 8'h42, 16'h000C, 0, 0, 0);
      step("R8", 1, 8'h02, 16'h0100, 0, 0, 0);
      step("R8", 1, 8'h06, 16'h0002, 0, 0, 0);
      step("R8", 1, 8'h04, 16'h0000, 0, 0, 0);
      step("R8", 1, 8'h00, 16'h0150, 0, 0, 0);
      for (int i = 0; i < 4; i++) step("R9", 0, 8'h00, 16'h0, 1, 0, 0);
      // R11 gate and mask
      step("R11", 1, 8'h42, 16'h000D, 0, 0, 0);
      step("R11", 0, 8'h00, 16'h0, 0, 0, 1);
      step("R11", 0, 8'h00, 16'h0, 0, 0, 0);
      // R10 clear, then set wins against clear
      step("R10", 1, 8'h42, 16'h000E, 0, 0, 1);
      step("R10", 1, 8'h04, 16'h0001, 0, 0, 1);
      step("R10", 1, 8'h42, 16'h000F, 1, 0, 1);
      // R12 write wins over transfer update
      step("R3", 1, 8'h42, 16'h0080, 0, 0, 0);
      step("R12", 1, 8'h08, 16'hAAAA, 1, 1, 0);
      step("R12", 1, 8'h0C, 16'h0005, 1, 1, 0);
      // R4 unmapped writes ignored
      step("R4", 1, 8'h44, 16'hFFFF, 0, 0, 0);
      step("R4", 1, 8'h20, 16'hFFFF, 0, 0, 0);
      step("R4", 1, 8'h01, 16'hFFFF, 0, 0, 0);

      void'($urandom(32'h5EED_0A17));
      for (int i = 0; i < 1500; i++) begin
         r = int'($urandom % 20);
         if (r < 16)       a = 8'((r / 4) * 8 + (r % 4) * 2);
         else if (r == 16) a = 8'h40;
         else if (r < 19)  a = 8'h42;
         else              a = 8'($urandom % 256);
         d = 16'($urandom);
         if (a < 8'h20 && a[2]) d = d & 16'h0007;
         step("", ($urandom % 3) == 0, a, d, ($urandom % 2) == 0,
              2'($urandom % 4), ($urandom % 4) != 0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule